// File: doc/BRIEF.md
# Programmable LCD Raster Timing Generator

This block produces the raster timing for a parallel display panel. Software programs a horizontal timing word, a vertical timing word, a frame-buffer start address and a control word through a simple 32-bit write/read port. Once enabled, the block steps a pixel counter and a line counter without pause and drives horizontal sync, vertical sync, data-enable and the byte address of the pixel being shown. It repeats frames for as long as the enable bit stays set.

Each line runs through sync, back porch, active pixels and front porch, in that order. Each frame runs through the same four phases, counted in whole lines. Every porch and sync length is programmed as its count minus one. The active width is programmed in units of 16 pixels, also minus one. The timing words, the start address, the pixel format and the red/blue swap flag are copied into shadow registers at the first clock of every frame. A write made during a frame therefore takes effect only from the next frame. The pixel format code sets how many bits of storage each pixel takes, and the address advances by exactly that amount.

Top module: `raster_timer`

## Requirements
- R1: The register offsets are 0x000 for the horizontal word, 0x004 for the vertical word, 0x010 for the frame start address, 0x014 for the second-panel address and 0x018 for control. A read returns the register one cycle after the read strobe. Bits 1:0 of the horizontal word and every control bit outside 11, 8 and 3:0 read as zero. Any other offset reads as zero and ignores writes.
- R2: The horizontal word holds sync width-1 in bits 15:8. hsync is high for (sync width-1)+1 clocks at the start of every line. The line period is the sum of the four phases.
- R3: The horizontal word holds back porch-1 in bits 31:24, front porch-1 in 23:16 and (active width/16)-1 in 7:2. de rises (sync+back porch) clocks after hsync rises and stays high for the active width. de never overlaps hsync or vsync.
- R4: The vertical word holds back porch-1 in bits 31:24, front porch-1 in 23:16, sync lines-1 in 15:10 and active lines-1 in 9:0. vsync lasts the sync lines times the line period. Each frame carries the programmed number of active lines. A frame lasts total lines times the line period.
- R5: The first active pixel of each frame has the frame start address. With format code 5 (24-bit colour in 32-bit words), each following active pixel is 4 bytes further on.
- R6: Control bits 3:1 select the storage bits per pixel, shown on pix_bits_o: codes 0..7 give 1, 2, 4, 8, 16, 32, 16 and 16. The address of pixel k of a frame is start + floor(k*bits/8).
- R7: The timing words, start address, format and swap flag written during a frame leave that frame unchanged and apply from the next frame.
- R8: Control bit 0 enables the block. Starting from the second clock edge after it is cleared, hsync, vsync and de stay low. When the bit is set again, a new frame begins with hsync and vsync rising together.
- R9: rb_swap_o follows control bit 8, taking the shadowed value at each frame start. panel_pwr_o follows control bit 11 directly.
- R10: single_panel_o is high exactly when the second-panel address register is zero.
- R11: After reset, all registers read zero and hsync, vsync and de are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low reset |
| reg_wr_en_i | input | 1 | Register write strobe |
| reg_rd_en_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wr_data_i | input | 32 | Write data |
| reg_rd_data_o | output | 32 | Read data, valid the cycle after the read strobe |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| de_o | output | 1 | Data enable during active pixels |
| pix_addr_o | output | 32 | Byte address of the pixel shown while de_o is high |
| pix_bits_o | output | 6 | Storage bits per pixel of the current frame |
| rb_swap_o | output | 1 | Red/blue swap flag of the current frame |
| panel_pwr_o | output | 1 | Panel power request |
| single_panel_o | output | 1 | High when the second-panel address is zero |

## Verification
The raster is measured from edge-to-edge distances on the outputs, never from absolute latency. Pulse widths, the de offset from hsync, the line period, the frame period and the active-line count show whether each field is decoded and counted with the right minus-one rule. The address stream is compared pixel by pixel at 32, 16, 8 and 1 bits per pixel, which separates byte, halfword and sub-byte stepping and checks the return to the start address. A frame into which new timing, address and format words are written mid-way shows whether the shadow copy waits for the frame boundary. A disable pulse issued during active video checks both the quiet outputs and the restart on a fresh frame.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int CntW     = 12;
  localparam int PixBitsW = 6;

  typedef struct packed {
    logic [CntW-1:0] hSyncEnd;
    logic [CntW-1:0] hActBeg;
    logic [CntW-1:0] hActEnd;
    logic [CntW-1:0] hLast;
    logic [CntW-1:0] vSyncEnd;
    logic [CntW-1:0] vActBeg;
    logic [CntW-1:0] vActEnd;
    logic [CntW-1:0] vLast;
  } rtgLimits_t;

  typedef struct packed {
    logic run;
    logic frameLoad;
    logic hSync;
    logic vSync;
    logic pixOn;
  } rtgStrobe_t;

  typedef enum logic [2:0] {
    FMT_1 = 3'd0, FMT_2 = 3'd1, FMT_4 = 3'd2, FMT_8 = 3'd3,
    FMT_16 = 3'd4, FMT_24W = 3'd5, FMT_565 = 3'd6, FMT_444 = 3'd7
  } rtgFmt_e;

  function automatic logic [PixBitsW-1:0] fmtStorageBits(input logic [2:0] code);
    logic [PixBitsW-1:0] bits;
    case (rtgFmt_e'(code))
      FMT_1:   bits = 6'd1;
      FMT_2:   bits = 6'd2;
      FMT_4:   bits = 6'd4;
      FMT_8:   bits = 6'd8;
      FMT_16:  bits = 6'd16;
      FMT_24W: bits = 6'd32;
      default: bits = 6'd16;
    endcase
    return bits;
  endfunction
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
#(
  parameter int AddrW = 8,
  parameter int DataW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wrEn_i,
  input  logic             rdEn_i,
  input  logic [AddrW-1:0] addr_i,
  input  logic [DataW-1:0] wrData_i,
  output logic [DataW-1:0] rdData_o,
  input  logic             frameLoad_i,
  output rtgLimits_t       lim_o,
  output logic [DataW-1:0] base_o,
  output logic [2:0]       fmt_o,
  output logic             swap_o,
  output logic             enable_o,
  output logic             panelPwr_o,
  output logic             singlePanel_o
);
  localparam logic [AddrW-1:0] OffHor  = AddrW'('h00);
  localparam logic [AddrW-1:0] OffVer  = AddrW'('h04);
  localparam logic [AddrW-1:0] OffBase = AddrW'('h10);
  localparam logic [AddrW-1:0] OffLow  = AddrW'('h14);
  localparam logic [AddrW-1:0] OffCtl  = AddrW'('h18);
  localparam logic [DataW-1:0] HorMask = DataW'('hFFFF_FFFC);
  localparam logic [DataW-1:0] CtlMask = DataW'('h0000_090F);

  logic [DataW-1:0] horWord, verWord, upBase, lowBase, ctlWord;
  rtgLimits_t       nextLim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      horWord <= '0;
      verWord <= '0;
      upBase  <= '0;
      lowBase <= '0;
      ctlWord <= '0;
    end else if (wrEn_i) begin
      case (addr_i)
        OffHor:  horWord <= wrData_i & HorMask;
        OffVer:  verWord <= wrData_i;
        OffBase: upBase  <= wrData_i;
        OffLow:  lowBase <= wrData_i;
        OffCtl:  ctlWord <= wrData_i & CtlMask;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdData_o <= '0;
    end else if (rdEn_i) begin
      case (addr_i)
        OffHor:  rdData_o <= horWord;
        OffVer:  rdData_o <= verWord;
        OffBase: rdData_o <= upBase;
        OffLow:  rdData_o <= lowBase;
        OffCtl:  rdData_o <= ctlWord;
        default: rdData_o <= '0;
      endcase
    end
  end

  // Phase boundaries, computed once per frame rather than per pixel
  always_comb begin
    logic [CntW-1:0] hSw, hBp, hFp, actW, vSw, vBp, vFp, actL;
    hSw  = CntW'(horWord[15:8]);
    hBp  = CntW'(horWord[31:24]);
    hFp  = CntW'(horWord[23:16]);
    actW = CntW'({horWord[7:2], 4'b0000}) + CntW'(16);
    vSw  = CntW'(verWord[15:10]);
    vBp  = CntW'(verWord[31:24]);
    vFp  = CntW'(verWord[23:16]);
    actL = CntW'(verWord[9:0]) + CntW'(1);
    nextLim.hSyncEnd = hSw + CntW'(1);
    nextLim.hActBeg  = hSw + hBp + CntW'(2);
    nextLim.hActEnd  = nextLim.hActBeg + actW;
    nextLim.hLast    = nextLim.hActEnd + hFp;
    nextLim.vSyncEnd = vSw + CntW'(1);
    nextLim.vActBeg  = vSw + vBp + CntW'(2);
    nextLim.vActEnd  = nextLim.vActBeg + actL;
    nextLim.vLast    = nextLim.vActEnd + vFp;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_o  <= '0;
      base_o <= '0;
      fmt_o  <= '0;
      swap_o <= 1'b0;
    end else if (frameLoad_i) begin
      lim_o  <= nextLim;
      base_o <= upBase;
      fmt_o  <= ctlWord[3:1];
      swap_o <= ctlWord[8];
    end
  end

  assign enable_o      = ctlWord[0];
  assign panelPwr_o    = ctlWord[11];
  assign singlePanel_o = (lowBase == '0);

  p_shadow_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frameLoad_i |=> $stable(lim_o) && $stable(base_o) && $stable(fmt_o) && $stable(swap_o));
endmodule

// File: rtl/rtg_ctrl.sv
module rtg_ctrl
  import rtg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enable_i,
  input  rtgLimits_t lim_i,
  output rtgStrobe_t strobe_o
);
  logic            running;
  logic [CntW-1:0] hCnt, vCnt;
  logic            lineEnd, frameEnd;

  assign lineEnd  = (hCnt == lim_i.hLast);
  assign frameEnd = lineEnd && (vCnt == lim_i.vLast);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running <= 1'b0;
      hCnt    <= '0;
      vCnt    <= '0;
    end else if (!enable_i) begin
      running <= 1'b0;
      hCnt    <= '0;
      vCnt    <= '0;
    end else if (!running) begin
      running <= 1'b1;
      hCnt    <= '0;
      vCnt    <= '0;
    end else if (lineEnd) begin
      hCnt <= '0;
      vCnt <= frameEnd ? '0 : vCnt + CntW'(1);
    end else begin
      hCnt <= hCnt + CntW'(1);
    end
  end

  always_comb begin
    strobe_o.run       = enable_i && running;
    strobe_o.frameLoad = enable_i && (!running || frameEnd);
    strobe_o.hSync     = hCnt < lim_i.hSyncEnd;
    strobe_o.vSync     = vCnt < lim_i.vSyncEnd;
    strobe_o.pixOn     = (hCnt >= lim_i.hActBeg) && (hCnt < lim_i.hActEnd) &&
                         (vCnt >= lim_i.vActBeg) && (vCnt < lim_i.vActEnd);
  end

  p_hcnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running |-> hCnt <= lim_i.hLast);
  p_vcnt_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running |-> vCnt <= lim_i.vLast);
  p_de_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o.pixOn |-> !strobe_o.hSync && !strobe_o.vSync);
  p_idle_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (hCnt == '0) && (vCnt == '0) && !running);
endmodule

// File: rtl/rtg_datapath.sv
module rtg_datapath
  import rtg_pkg::*;
#(
  parameter int DataW = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  rtgStrobe_t          strobe_i,
  input  logic [DataW-1:0]    base_i,
  input  logic [2:0]          fmt_i,
  output logic                hsync_o,
  output logic                vsync_o,
  output logic                de_o,
  output logic [DataW-1:0]    pixAddr_o,
  output logic [PixBitsW-1:0] pixBits_o
);
  localparam int OffW = DataW + 3;

  logic [OffW-1:0] offBits;
  logic [OffW-1:0] stepBits;

  assign pixBits_o = fmtStorageBits(fmt_i);
  assign stepBits  = OffW'(pixBits_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hsync_o   <= 1'b0;
      vsync_o   <= 1'b0;
      de_o      <= 1'b0;
      pixAddr_o <= '0;
      offBits   <= '0;
    end else begin
      hsync_o <= strobe_i.run && strobe_i.hSync;
      vsync_o <= strobe_i.run && strobe_i.vSync;
      de_o    <= strobe_i.run && strobe_i.pixOn;
      if (strobe_i.frameLoad) begin
        offBits <= '0;
      end else if (strobe_i.run && strobe_i.pixOn) begin
        pixAddr_o <= base_i + offBits[OffW-1:3];
        offBits   <= offBits + stepBits;
      end
    end
  end

  p_addr_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (de_o && $past(de_o) && (pixBits_o == 6'd32)) |-> pixAddr_o == $past(pixAddr_o) + DataW'(4));
  p_sync_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> !hsync_o && !vsync_o);
endmodule

// File: rtl/raster_timer.sv
module raster_timer
  import rtg_pkg::*;
#(
  parameter int AddrW = 8,
  parameter int DataW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_en_i,
  input  logic             reg_rd_en_i,
  input  logic [AddrW-1:0] reg_addr_i,
  input  logic [DataW-1:0] reg_wr_data_i,
  output logic [DataW-1:0] reg_rd_data_o,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic [DataW-1:0] pix_addr_o,
  output logic [5:0]       pix_bits_o,
  output logic             rb_swap_o,
  output logic             panel_pwr_o,
  output logic             single_panel_o
);
  rtgLimits_t       shadLim;
  rtgStrobe_t       strobe;
  logic [DataW-1:0] shadBase;
  logic [2:0]       shadFmt;
  logic             enable;

  rtg_regs #(.AddrW(AddrW), .DataW(DataW)) regs_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wrEn_i        (reg_wr_en_i),
    .rdEn_i        (reg_rd_en_i),
    .addr_i        (reg_addr_i),
    .wrData_i      (reg_wr_data_i),
    .rdData_o      (reg_rd_data_o),
    .frameLoad_i   (strobe.frameLoad),
    .lim_o         (shadLim),
    .base_o        (shadBase),
    .fmt_o         (shadFmt),
    .swap_o        (rb_swap_o),
    .enable_o      (enable),
    .panelPwr_o    (panel_pwr_o),
    .singlePanel_o (single_panel_o)
  );

  rtg_ctrl ctrl_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable),
    .lim_i    (shadLim),
    .strobe_o (strobe)
  );

  rtg_datapath #(.DataW(DataW)) dp_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strobe_i  (strobe),
    .base_i    (shadBase),
    .fmt_i     (shadFmt),
    .hsync_o   (hsync_o),
    .vsync_o   (vsync_o),
    .de_o      (de_o),
    .pixAddr_o (pix_addr_o),
    .pixBits_o (pix_bits_o)
  );
endmodule

// File: tb/raster_timer_tb_top.sv
`timescale 1ns/1ps
module raster_timer_tb_top;
  localparam int ClkPer = 8;
  localparam int HS = 2, VS = 1, DE = 0;
  localparam logic [7:0] A_HOR = 8'h00, A_VER = 8'h04, A_BASE = 8'h10, A_LOW = 8'h14, A_CTL = 8'h18;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData, pixAddr;
  logic        hsync, vsync, de, rbSwap, panelPwr, singlePanel;
  logic [5:0]  pixBits;
  int          chkCnt = 0, failCnt = 0;
  bit          done = 1'b0;

  always #(ClkPer/2) clk = ~clk;

  raster_timer dut_i (
    .clk_i(clk), .rst_ni(rstN), .reg_wr_en_i(wrEn), .reg_rd_en_i(rdEn),
    .reg_addr_i(addr), .reg_wr_data_i(wrData), .reg_rd_data_o(rdData),
    .hsync_o(hsync), .vsync_o(vsync), .de_o(de), .pix_addr_o(pixAddr),
    .pix_bits_o(pixBits), .rb_swap_o(rbSwap), .panel_pwr_o(panelPwr),
    .single_panel_o(singlePanel)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    chkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rdEn = 1'b1; addr = a;
    @(negedge clk); d = rdData; rdEn = 1'b0;
  endtask

  task automatic stepUntil(input int idx, input logic lvl);
    for (int n = 0; n < 5000; n++) begin
      logic [2:0] v;
      @(negedge clk);
      v = {hsync, vsync, de};
      if (v[idx] == lvl) return;
    end
  endtask

  function automatic int cyclesSince(input time t0);
    return int'(($time - t0) / ClkPer);
  endfunction

  task automatic scanFrame(input int bits, input logic [31:0] base,
                           output int vsLen, output int frameLen, output int deLines,
                           output int deCyc, output int firstDeOff, output int addrBad,
                           output logic [31:0] firstAddr);
    time  tRise;
    logic pVs, pDe;
    int   k;
    vsLen = 0; frameLen = 0; deLines = 0; deCyc = 0; firstDeOff = 0; addrBad = 0;
    firstAddr = '0; k = 0;
    stepUntil(VS, 1'b0);
    stepUntil(VS, 1'b1);
    tRise = $time; pVs = 1'b1; pDe = de;
    for (int n = 0; n < 5000; n++) begin
      @(negedge clk);
      if (pVs && !vsync) vsLen = cyclesSince(tRise);
      if (!pVs && vsync) begin
        frameLen = cyclesSince(tRise);
        break;
      end
      if (de) begin
        longint expA;
        if (!pDe) begin
          deLines++;
          if (deLines == 1) firstDeOff = cyclesSince(tRise);
        end
        if (k == 0) firstAddr = pixAddr;
        expA = longint'(base) + (longint'(k) * bits) / 8;
        if (longint'(pixAddr) != expA) addrBad++;
        k++; deCyc++;
      end
      pVs = vsync; pDe = de;
    end
  endtask

  function automatic int expBits(input int code);
    case (code)
      0: return 1;  1: return 2;  2: return 4;  3: return 8;
      4: return 16; 5: return 32; default: return 16;
    endcase
  endfunction

  // R11: reset state
  task automatic tReset();
    logic [31:0] d;
    int highs = 0;
    chk("R11 hsync after reset", hsync, 0);
    chk("R11 vsync after reset", vsync, 0);
    chk("R11 de after reset", de, 0);
    regRead(A_CTL, d);  chk("R11 control reads zero", d, 0);
    regRead(A_HOR, d);  chk("R11 horizontal reads zero", d, 0);
    regRead(A_BASE, d); chk("R11 base reads zero", d, 0);
    for (int n = 0; n < 50; n++) begin
      @(negedge clk);
      if (hsync || vsync || de) highs++;
    end
    chk("R11 outputs stay low while disabled", highs, 0);
    chk("R10 single panel after reset", singlePanel, 1);
  endtask

  // R1, R10: register map
  task automatic tRegs();
    logic [31:0] d;
    regWrite(A_HOR, 32'hFFFF_FFFF); regRead(A_HOR, d);
    chk("R1 horizontal low bits read zero", d, 32'hFFFF_FFFC);
    regWrite(A_CTL, 32'hFFFF_FFFE); regRead(A_CTL, d);
    chk("R1 control reserved bits read zero", d, 32'h0000_090E);
    regWrite(A_CTL, 32'h0);
    regWrite(A_VER, 32'h1234_5678); regRead(A_VER, d);
    chk("R1 vertical readback", d, 32'h1234_5678);
    regWrite(8'h08, 32'hDEAD_BEEF); regRead(8'h08, d);
    chk("R1 unmapped offset reads zero", d, 0);
    regRead(A_VER, d);
    chk("R1 unmapped write leaves vertical", d, 32'h1234_5678);
    regWrite(A_LOW, 32'h0000_1000); @(negedge clk);
    chk("R10 second panel address set", singlePanel, 0);
    regWrite(A_LOW, 32'h0); @(negedge clk);
    chk("R10 second panel address cleared", singlePanel, 1);
  endtask

  // R2, R3: one line
  task automatic tLine();
    time t0, t1, t2, t3, t4;
    stepUntil(VS, 1'b1); stepUntil(VS, 1'b0);
    stepUntil(DE, 1'b1); t0 = $time;
    stepUntil(DE, 1'b0); t1 = $time;
    stepUntil(HS, 1'b1); t2 = $time;
    stepUntil(HS, 1'b0); t3 = $time;
    stepUntil(DE, 1'b1); t4 = $time;
    chk("R3 de width", int'((t1 - t0) / ClkPer), 16);
    chk("R2 hsync width", int'((t3 - t2) / ClkPer), 2);
    chk("R3 de offset from hsync", int'((t4 - t2) / ClkPer), 5);
    chk("R2 line period", int'((t4 - t0) / ClkPer), 23);
  endtask

  // R4, R5, R9: full frame at 32 bits per pixel
  task automatic tFrame32();
    int vsLen, frameLen, deLines, deCyc, firstDeOff, addrBad;
    logic [31:0] fa;
    scanFrame(32, 32'h0010_0000, vsLen, frameLen, deLines, deCyc, firstDeOff, addrBad, fa);
    chk("R4 vsync length", vsLen, 23);
    chk("R4 frame period", frameLen, 184);
    chk("R4 active lines", deLines, 4);
    chk("R4 active pixels", deCyc, 64);
    chk("R4 first de offset", firstDeOff, 74);
    chk("R5 first address equals base", fa, 32'h0010_0000);
    chk("R5 32-bit address stepping", addrBad, 0);
    chk("R6 code 5 storage bits", pixBits, 32);
    chk("R9 swap flag", rbSwap, 1);
    chk("R9 panel power", panelPwr, 1);
    scanFrame(32, 32'h0010_0000, vsLen, frameLen, deLines, deCyc, firstDeOff, addrBad, fa);
    chk("R5 address returns to base next frame", fa, 32'h0010_0000);
  endtask

  // R7: mid-frame writes
  task automatic tShadow();
    time t0, t1;
    int vsLen, frameLen, deLines, deCyc, firstDeOff, addrBad;
    logic [31:0] fa;
    stepUntil(VS, 1'b1); stepUntil(VS, 1'b0);
    regWrite(A_HOR, 32'h0401_0100);
    regWrite(A_BASE, 32'h0020_0000);
    regWrite(A_CTL, 32'h0000_0809);
    chk("R7 swap held mid-frame", rbSwap, 1);
    chk("R7 format held mid-frame", pixBits, 32);
    stepUntil(DE, 1'b1); t0 = $time;
    chk("R7 base held mid-frame", pixAddr, 32'h0010_0000);
    stepUntil(DE, 1'b0); stepUntil(DE, 1'b1); t1 = $time;
    chk("R7 old line period kept", int'((t1 - t0) / ClkPer), 23);
    scanFrame(16, 32'h0020_0000, vsLen, frameLen, deLines, deCyc, firstDeOff, addrBad, fa);
    chk("R7 new frame period", frameLen, 200);
    chk("R7 new first de offset", firstDeOff, 82);
    chk("R7 new base", fa, 32'h0020_0000);
    chk("R6 16-bit address stepping", addrBad, 0);
    chk("R9 swap cleared at frame", rbSwap, 0);
    regWrite(A_CTL, 32'h0000_0009); @(negedge clk);
    chk("R9 panel power follows at once", panelPwr, 0);
  endtask

  // R6: format decode and sub-byte stepping
  task automatic tFormats();
    int vsLen, frameLen, deLines, deCyc, firstDeOff, addrBad;
    logic [31:0] fa;
    for (int code = 0; code < 8; code++) begin
      regWrite(A_CTL, 32'h0000_0801 | (code << 1));
      stepUntil(VS, 1'b0); stepUntil(VS, 1'b1);
      chk($sformatf("R6 storage bits code %0d", code), pixBits, expBits(code));
    end
    regWrite(A_CTL, 32'h0000_0801);
    scanFrame(1, 32'h0020_0000, vsLen, frameLen, deLines, deCyc, firstDeOff, addrBad, fa);
    chk("R6 1-bit address stepping", addrBad, 0);
    regWrite(A_CTL, 32'h0000_0807);
    scanFrame(8, 32'h0020_0000, vsLen, frameLen, deLines, deCyc, firstDeOff, addrBad, fa);
    chk("R6 8-bit address stepping", addrBad, 0);
  endtask

  // R8: disable and restart
  task automatic tDisable();
    int highs = 0;
    stepUntil(DE, 1'b1);
    regWrite(A_CTL, 32'h0000_0800);
    @(negedge clk);
    chk("R8 de low after disable", de, 0);
    for (int n = 0; n < 300; n++) begin
      @(negedge clk);
      if (hsync || vsync || de) highs++;
    end
    chk("R8 outputs quiet while disabled", highs, 0);
    regWrite(A_CTL, 32'h0000_080B);
    stepUntil(VS, 1'b1);
    chk("R8 restart hsync with vsync", hsync, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tRegs();
    regWrite(A_HOR, 32'h0201_0100);
    regWrite(A_VER, 32'h0100_0003);
    regWrite(A_BASE, 32'h0010_0000);
    regWrite(A_CTL, 32'h0000_090B);
    tLine();
    tFrame32();
    tShadow();
    tFormats();
    tDisable();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", chkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chkCnt++; failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", chkCnt, failCnt);
      $finish;
    end
  end
endmodule